// File: doc/BRIEF.md
# Pruned Five-Stage Comb Differentiator

This block is the differencing half of a decimating cascaded integrator-comb filter. A 26-bit two's complement sample arrives from the decimation register. It passes through five first-difference stages in series. Each stage subtracts from its present input the input it saw at the previous decimated sample. The cascade works at the low rate only. A single-cycle strobe `stb` marks each decimated sample. On any other cycle, every register in the cascade holds its value.

The stages are pruned. Their widths are 26, 22, 21, 20 and 19 bits, in cascade order. Each width step drops least significant bits: four bits after the first stage, then one bit after each later stage. The 19-bit result of the last stage is registered and goes to a downstream rounder, together with a one-cycle valid flag.

Each stage has its own enable bit. A disabled stage forwards its input unchanged and holds its delay register at zero. A synchronous clear empties the whole cascade without a reset.

Top module: `cdiff_cascade`

## Requirements
- R1: After reset, `y_out` is 0 and `y_vld` is 0. All delay registers are zero, so the first strobe with every stage enabled yields `x_in[25:7]`.
- R2: `y_vld` is high for exactly the cycle after each cycle in which `stb` is high and `clr` is low. It is low at all other times.
- R3: `y_out` changes only on the clock edge that samples `stb` high or `clr` high.
- R4: With stage k enabled (bit k-1 of `stage_en`), that stage outputs its input minus its input at the previous strobe. The cascade of five enabled stages therefore returns 0 from the sixth strobe of a constant input onward.
- R5: Stage widths are 26, 22, 21, 20 and 19 bits. Between stages the value keeps its upper bits: 4 low bits are dropped after stage 1, and 1 low bit after each of stages 2, 3 and 4. With all enables low, the output equals `x_in[25:7]`.
- R6: Every subtraction wraps modulo two to the power of its stage width, with no saturation.
- R7: A stage whose enable bit is low passes its input through and keeps its delay register at zero. When the bit is raised again, the first difference that stage produces equals its input.
- R8: `clr` high at a clock edge zeroes every delay register and `y_out`, and sets `y_vld` low on the next cycle.
- R9: A change of `x_in` while `stb` is low has no effect on the output or on any delay register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all stage state and the output |
| stb | input | 1 | Decimated-sample strobe, one cycle wide |
| stage_en | input | 5 | Per-stage enable; bit 0 is the first stage |
| x_in | input | 26 | Two's complement sample from the decimation register |
| y_out | output | 19 | Result of the last stage, to the rounder |
| y_vld | output | 1 | High the cycle after a strobe is taken |

## Verification
Several input patterns are applied, and each one separates a different failure. A constant level must settle to zero after exactly five differences, which exposes a missing or extra stage. A lone impulse reproduces the alternating binomial response, which checks the order and delay of each stage. Alternating full-scale positive and negative samples force every subtractor to wrap, so any saturation or wrong borrow into a narrower stage shows up. With all enables low, the bit selection of the pruning becomes visible directly. Disabling one middle stage and then enabling it again shows whether its delay was truly held at zero. Moving the input between strobes, and clearing in the middle of a run, show whether state leaks outside the strobe or survives a clear.

// File: rtl/cdiff_pkg.sv
package cdiff_pkg;

  localparam int NSTG = 5;
  localparam int CW [NSTG] = '{26, 22, 21, 20, 19};
  localparam int IN_W  = CW[0];
  localparam int OUT_W = CW[NSTG-1];

  // width of link segment k: input of stage k, or the cascade output for k == NSTG
  function automatic int seg_w(input int k);
    return (k < NSTG) ? CW[k] : CW[NSTG-1];
  endfunction

  // bit offset of link segment k inside the flat inter-stage bus
  function automatic int link_off(input int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += seg_w(i);
    return s;
  endfunction

endpackage

// File: rtl/cdiff_rst_sync.sv
module cdiff_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/cdiff_stage.sv
module cdiff_stage #(
  parameter int IN_W  = 26,
  parameter int OUT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  input  logic             en,
  input  logic [IN_W-1:0]  x,
  output logic [OUT_W-1:0] q
);
  localparam int DROP = IN_W - OUT_W;

  logic [IN_W-1:0]  dly_q;
  logic [IN_W-1:0]  dly_d;
  logic [OUT_W-1:0] diff_hi;

  // only the kept upper bits of the difference are formed; the dropped
  // low part contributes nothing but its borrow
  generate
    if (DROP > 0) begin : g_pruned
      logic borrow;
      always_comb begin
        borrow  = (x[DROP-1:0] < dly_q[DROP-1:0]);
        diff_hi = x[IN_W-1:DROP] - dly_q[IN_W-1:DROP] - {{(OUT_W-1){1'b0}}, borrow};
      end
    end else begin : g_full
      always_comb begin
        diff_hi = x - dly_q;
      end
    end
  endgenerate

  always_comb begin
    q = en ? diff_hi : x[IN_W-1 -: OUT_W];
    dly_d = dly_q;
    if (clr || !en) dly_d = '0;
    else if (stb)   dly_d = x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end
endmodule

// File: rtl/cdiff_outreg.sv
module cdiff_outreg #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] y,
  output logic         vld
);
  logic [W-1:0] y_d;
  logic         vld_d;

  always_comb begin
    y_d   = y;
    vld_d = 1'b0;
    if (clr) begin
      y_d = '0;
    end else if (stb) begin
      y_d   = d;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y   <= '0;
      vld <= 1'b0;
    end else begin
      y   <= y_d;
      vld <= vld_d;
    end
  end
endmodule

// File: rtl/cdiff_cascade.sv
module cdiff_cascade
  import cdiff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  input  logic [NSTG-1:0]  stage_en,
  input  logic [IN_W-1:0]  x_in,
  output logic [OUT_W-1:0] y_out,
  output logic             y_vld
);
  localparam int LINK_W = link_off(NSTG + 1);

  logic              rst_q_n;
  logic [LINK_W-1:0] link;

  cdiff_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign link[link_off(0) +: seg_w(0)] = x_in;

  generate
    for (genvar k = 0; k < NSTG; k++) begin : g_stg
      cdiff_stage #(
        .IN_W  (seg_w(k)),
        .OUT_W (seg_w(k + 1))
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_q_n),
        .clr   (clr),
        .stb   (stb),
        .en    (stage_en[k]),
        .x     (link[link_off(k) +: seg_w(k)]),
        .q     (link[link_off(k + 1) +: seg_w(k + 1)])
      );
    end
  endgenerate

  cdiff_outreg #(.W(OUT_W)) u_out (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (clr),
    .stb   (stb),
    .d     (link[link_off(NSTG) +: OUT_W]),
    .y     (y_out),
    .vld   (y_vld)
  );
endmodule

// File: rtl/cdiff_cascade_chk.sv
module cdiff_cascade_chk
  import cdiff_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             stb,
  input logic [NSTG-1:0]  stage_en,
  input logic [IN_W-1:0]  x_in,
  input logic [OUT_W-1:0] y_out,
  input logic             y_vld
);
  // R2
  vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !clr) |=> y_vld);

  // R2
  vld_only_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !y_vld);

  // R3
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !clr) |=> $stable(y_out));

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (y_out == '0 && !y_vld));

  // R5
  all_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !clr && stage_en == '0) |=> (y_out == $past(x_in[IN_W-1 -: OUT_W])));
endmodule

bind cdiff_cascade cdiff_cascade_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .stb      (stb),
  .stage_en (stage_en),
  .x_in     (x_in),
  .y_out    (y_out),
  .y_vld    (y_vld)
);

// File: tb/cdiff_cascade_tb_top.sv
module cdiff_cascade_tb_top;
  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        stb;
  logic [4:0]  en;
  logic [25:0] x_in;
  logic [18:0] y_out;
  logic        y_vld;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  int    BW [5] = '{26, 22, 21, 20, 19};
  longint m_d [5];

  cdiff_cascade dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .stb      (stb),
    .stage_en (en),
    .x_in     (x_in),
    .y_out    (y_out),
    .y_vld    (y_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference cascade, evaluated once per strobe
  task automatic model(input logic [25:0] x, output logic [18:0] e);
    longint v;
    longint o;
    longint msk;
    int w;
    int wn;
    v = longint'(x);
    for (int k = 0; k < 5; k++) begin
      w   = BW[k];
      wn  = (k < 4) ? BW[k+1] : 19;
      msk = (longint'(1) << w) - 1;
      if (en[k]) begin
        o = (v - m_d[k]) & msk;
        m_d[k] = v;
      end else begin
        o = v;
        m_d[k] = 0;
      end
      v = o >> (w - wn);
    end
    e = v[18:0];
  endtask

  task automatic model_clear();
    for (int k = 0; k < 5; k++) m_d[k] = 0;
  endtask

  task automatic strobe(input logic [25:0] x, input string req);
    logic [18:0] e;
    @(negedge clk);
    x_in = x;
    stb  = 1'b1;
    model(x, e);
    @(negedge clk);
    stb = 1'b0;
    chk(req, y_out, e);
    chk({req, " valid"}, y_vld, 1);
  endtask

  task automatic set_en(input logic [4:0] v);
    @(negedge clk);
    en = v;
    for (int k = 0; k < 5; k++) if (!v[k]) m_d[k] = 0;
  endtask

  task automatic do_clear(input string req);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
    chk(req, y_out, 0);
    chk({req, " valid"}, y_vld, 0);
  endtask

  task automatic t_reset();
    chk("R1 output after reset", y_out, 0);
    chk("R1 valid after reset", y_vld, 0);
    set_en(5'b11111);
    strobe(26'h12345AB, "R1 first sample");
    chk("R1 first sample equals upper input bits", y_out, 26'h12345AB >> 7);
  endtask

  task automatic t_passthru();
    logic [25:0] vals [4] = '{26'h3FFFFFF, 26'h0000080, 26'h000007F, 26'h2ABCDEF};
    set_en(5'b00000);
    foreach (vals[i]) begin
      strobe(vals[i], "R5 bypass");
      chk("R5 pruning keeps bits 25..7", y_out, vals[i] >> 7);
    end
  endtask

  task automatic t_dc();
    do_clear("R8 clear before dc");
    set_en(5'b11111);
    for (int i = 0; i < 8; i++) begin
      strobe(26'h0400000, "R4 constant input");
      if (i >= 5) chk("R4 constant settles to zero", y_out, 0);
    end
  endtask

  task automatic t_impulse();
    do_clear("R8 clear before impulse");
    strobe(26'h0800000, "R4 impulse head");
    for (int i = 0; i < 7; i++) strobe(26'h0, "R4 impulse tail");
  endtask

  task automatic t_wrap();
    do_clear("R8 clear before wrap");
    for (int i = 0; i < 6; i++) begin
      strobe(26'h1FFFFFF, "R6 wrap positive");
      strobe(26'h2000000, "R6 wrap negative");
    end
  endtask

  task automatic t_valid();
    strobe(26'h0012345, "R2 strobe");
    @(negedge clk);
    chk("R2 valid drops after one cycle", y_vld, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 no valid while idle", y_vld, 0);
    end
  endtask

  task automatic t_hold();
    logic [18:0] held;
    strobe(26'h0300000, "R9 setup");
    held = y_out;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      x_in = 26'h1555555 ^ (26'h0F0F0F * i);
      @(negedge clk);
      chk("R3 output stable without strobe", y_out, held);
      chk("R9 no valid without strobe", y_vld, 0);
    end
    strobe(26'h0310000, "R9 delays untouched by unstrobed input");
  endtask

  task automatic t_enable();
    do_clear("R8 clear before enable test");
    set_en(5'b11011);
    for (int i = 0; i < 6; i++) strobe(26'h0040000 * (i + 1), "R7 middle stage off");
    set_en(5'b11111);
    for (int i = 0; i < 4; i++) strobe(26'h0200000 + 26'h0011000 * i, "R7 stage re-enabled");
  endtask

  task automatic t_clear();
    set_en(5'b11111);
    strobe(26'h0ABCDEF, "R8 pre clear");
    strobe(26'h1234567, "R8 pre clear");
    do_clear("R8 clear output");
    strobe(26'h0765432, "R8 delays cleared");
    chk("R8 first sample after clear", y_out, 26'h0765432 >> 7);
  endtask

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    stb   = 1'b0;
    en    = 5'b00000;
    x_in  = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_passthru();
    t_dc();
    t_impulse();
    t_wrap();
    t_valid();
    t_hold();
    t_enable();
    t_clear();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule